// File: doc/BRIEF.md
# Host Port Fast Gate Decoder

This block watches byte writes that a host processor makes into the input data register of a keyboard-controller-style host port. It drives one gate output straight from hardware, with no firmware or interrupt in the path. Each accepted write is classed as a command or a data byte by an address bit. A specific command value (0xD1) arms the decoder. The data byte that follows then has one of its bits copied onto the gate pin.

The host bus is asynchronous to the system clock. The write strobe, select, address bit and data therefore pass through a two-flop synchronizer. A write is recognised on the rising edge of the synchronized strobe. A control enable bit forces the gate low while it is cleared. An input-buffer-full flag marks each accepted write until a local acknowledge clears it. A flag shows whether the last accepted byte was a command or data.

Top module: `host_fast_gate`

## Requirements
- R1: After reset the gate output is 0, the decoder is not armed, the buffer-full flag is 0 and the command/data flag is 0.
- R2: A write made while the chip select input is 0 is ignored. It leaves the gate, the armed state, the buffer-full flag and the command/data flag unchanged.
- R3: An accepted write with the address bit at 1 is a command and one with it at 0 is data. The command/data flag shows 1 or 0 for the last accepted write.
- R4: A command of value 0xD1 arms the decoder. A following data byte with bit 1 equal to 1 drives the gate to 1.
- R5: When the decoder is armed, a data byte with bit 1 equal to 0 drives the gate to 0, whatever its other bits are.
- R6: The gate changes on the third rising clock edge after the host write strobe rises (two synchronizer stages and one edge-detect stage). It does not change while the strobe is still low.
- R7: A command other than 0xD1 received while armed abandons the sequence. The next data byte then leaves the gate unchanged.
- R8: A data byte that is not preceded by 0xD1 leaves the gate unchanged. After a data byte has been applied the decoder disarms, so a second data byte has no effect.
- R9: A second 0xD1 command received while armed keeps the decoder armed.
- R10: While the enable input is 0 the gate is held at 0 from the next clock edge on, and writes do not change it. Setting the enable to 1 again leaves the gate at 0 until a new armed data byte arrives.
- R11: The buffer-full flag is set by every accepted write and cleared by the read acknowledge input. If both fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host chip select for the fast-gate data register, active high |
| hst_cmd | input | 1 | Address bit: 1 = command, 0 = data |
| hst_wr_n | input | 1 | Host write strobe, active low; the write completes on its rising edge |
| hst_data | input | 8 | Host write data |
| gate_en | input | 1 | Fast gate enable from the control register |
| rd_ack | input | 1 | Local read acknowledge, clears the buffer-full flag |
| gate_out | output | 1 | Gate output |
| ibf | output | 1 | Input buffer full flag |
| cmd_flag | output | 1 | 1 if the last accepted write was a command |

## Verification
The buffer-full flag can be set by a host write and cleared by the read acknowledge in the same clock cycle. The bench provokes this by raising the acknowledge exactly in the cycle in which the synchronized strobe edge is registered, three edges after the strobe rises. It judges the outcome by the flag staying at 1. The enable being cleared in the same cycle as an armed data byte lands is a second collision, and there the gate must stay 0.

// File: rtl/hfg_pkg.sv
package hfg_pkg;
  localparam int unsigned HFG_DATA_W   = 8;
  localparam int unsigned HFG_STAGES   = 2;
  localparam int unsigned HFG_GATE_BIT = 1;
  localparam logic [HFG_DATA_W-1:0] HFG_ARM_CODE = 8'hD1;

  typedef struct packed {
    logic                  sel;
    logic                  cmd;
    logic [HFG_DATA_W-1:0] data;
  } hfg_wr_t;
endpackage

// File: rtl/hfg_rst_sync.sv
module hfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hfg_sync.sv
module hfg_sync
  import hfg_pkg::*;
#(
  parameter int unsigned DATA_W = HFG_DATA_W,
  parameter int unsigned STAGES = HFG_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              cmd_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              evt_o,
  output logic              sel_o,
  output logic              cmd_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned W = DATA_W + 3;
  localparam int unsigned LAST = STAGES - 1;
  localparam logic [W-1:0] IDLE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] stg_q [STAGES];
  logic         prev_wr_q;
  logic [W-1:0] raw;

  assign raw = {wr_n_i, sel_i, cmd_i, data_i};

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= IDLE;
        else        stg_q[i] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= IDLE;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_wr_q <= 1'b1;
    else        prev_wr_q <= stg_q[LAST][W-1];
  end

  assign evt_o  = stg_q[LAST][W-1] & ~prev_wr_q;
  assign sel_o  = stg_q[LAST][W-2];
  assign cmd_o  = stg_q[LAST][W-3];
  assign data_o = stg_q[LAST][DATA_W-1:0];

  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);  // R6
endmodule

// File: rtl/hfg_decode.sv
module hfg_decode
  import hfg_pkg::*;
#(
  parameter int unsigned           DATA_W   = HFG_DATA_W,
  parameter int unsigned           GATE_BIT = HFG_GATE_BIT,
  parameter logic [DATA_W-1:0]     ARM_CODE = HFG_ARM_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              sel_i,
  input  logic              cmd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              gate_en_i,
  input  logic              rd_ack_i,
  output logic              gate_o,
  output logic              ibf_o,
  output logic              cmd_flag_o
);
  logic accept, apply;
  logic armed_q, armed_d;
  logic gate_q, gate_d;
  logic ibf_q, ibf_d;
  logic cf_q, cf_d;

  assign accept = evt_i & sel_i;
  assign apply  = accept & ~cmd_i & armed_q;

  always_comb begin
    armed_d = armed_q;
    if (accept) begin
      if (cmd_i) armed_d = (data_i == ARM_CODE);
      else       armed_d = 1'b0;
    end
  end

  always_comb begin
    gate_d = gate_q;
    if (!gate_en_i)  gate_d = 1'b0;
    else if (apply)  gate_d = data_i[GATE_BIT];
  end

  always_comb begin
    ibf_d = ibf_q;
    if (rd_ack_i) ibf_d = 1'b0;
    if (accept)   ibf_d = 1'b1;
  end

  always_comb begin
    cf_d = cf_q;
    if (accept) cf_d = cmd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
      ibf_q   <= 1'b0;
      cf_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      gate_q  <= gate_d;
      ibf_q   <= ibf_d;
      cf_q    <= cf_d;
    end
  end

  assign gate_o     = gate_q;
  assign ibf_o      = ibf_q;
  assign cmd_flag_o = cf_q;

  AST_GATE_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en_i |=> !gate_q);  // R10
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_i && !apply) |=> $stable(gate_q));  // R8
  AST_DISARM_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_i) |=> !armed_q);  // R8
  AST_ARM_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_i && data_i == ARM_CODE) |=> armed_q);  // R4
  AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ibf_q);  // R11
  AST_IGNORE_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i && !rd_ack_i) |=> $stable(ibf_q) && $stable(cf_q));  // R2
endmodule

// File: rtl/host_fast_gate.sv
module host_fast_gate
  import hfg_pkg::*;
#(
  parameter int unsigned              DATA_W   = HFG_DATA_W,
  parameter int unsigned              STAGES   = HFG_STAGES,
  parameter int unsigned              GATE_BIT = HFG_GATE_BIT,
  parameter logic [DATA_W-1:0]        ARM_CODE = HFG_ARM_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel,
  input  logic              hst_cmd,
  input  logic              hst_wr_n,
  input  logic [DATA_W-1:0] hst_data,
  input  logic              gate_en,
  input  logic              rd_ack,
  output logic              gate_out,
  output logic              ibf,
  output logic              cmd_flag
);
  logic              rst_n_int;
  logic              evt;
  logic              s_sel, s_cmd;
  logic [DATA_W-1:0] s_data;

  hfg_rst_sync #(.STAGES(STAGES)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  hfg_sync #(.DATA_W(DATA_W), .STAGES(STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .sel_i  (hst_sel),
    .cmd_i  (hst_cmd),
    .wr_n_i (hst_wr_n),
    .data_i (hst_data),
    .evt_o  (evt),
    .sel_o  (s_sel),
    .cmd_o  (s_cmd),
    .data_o (s_data)
  );

  hfg_decode #(.DATA_W(DATA_W), .GATE_BIT(GATE_BIT), .ARM_CODE(ARM_CODE)) i_dec (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .evt_i      (evt),
    .sel_i      (s_sel),
    .cmd_i      (s_cmd),
    .data_i     (s_data),
    .gate_en_i  (gate_en),
    .rd_ack_i   (rd_ack),
    .gate_o     (gate_out),
    .ibf_o      (ibf),
    .cmd_flag_o (cmd_flag)
  );
endmodule

// File: tb/test_host_fast_gate.sv
module test_host_fast_gate;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hst_sel, hst_cmd, hst_wr_n, gate_en, rd_ack;
  logic [7:0] hst_data;
  logic       gate_out, ibf, cmd_flag;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  host_fast_gate i_host_fast_gate (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_cmd(hst_cmd),
    .hst_wr_n(hst_wr_n), .hst_data(hst_data), .gate_en(gate_en),
    .rd_ack(rd_ack), .gate_out(gate_out), .ibf(ibf), .cmd_flag(cmd_flag)
  );

  // {sel, cmd, data[7:0], expected gate, expected cmd_flag}
  localparam int NV = 15;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h02, 1'b0, 1'b0},  // data without arming
    {1'b1, 1'b1, 8'hD1, 1'b0, 1'b1},  // arm
    {1'b1, 1'b0, 8'h02, 1'b1, 1'b0},  // set
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0},  // disarmed, no effect
    {1'b1, 1'b1, 8'hD1, 1'b1, 1'b1},  // arm
    {1'b1, 1'b1, 8'hD1, 1'b1, 1'b1},  // re-arm
    {1'b1, 1'b0, 8'hFD, 1'b0, 1'b0},  // clear, other bits set
    {1'b1, 1'b1, 8'hD1, 1'b0, 1'b1},  // arm
    {1'b1, 1'b1, 8'hA5, 1'b0, 1'b1},  // other command abandons
    {1'b1, 1'b0, 8'hFF, 1'b0, 1'b0},  // no effect
    {1'b0, 1'b1, 8'hD1, 1'b0, 1'b0},  // unselected
    {1'b0, 1'b0, 8'h02, 1'b0, 1'b0},  // unselected
    {1'b1, 1'b1, 8'hD1, 1'b0, 1'b1},  // arm
    {1'b0, 1'b0, 8'h02, 1'b0, 1'b1},  // unselected, stays armed
    {1'b1, 1'b0, 8'h02, 1'b1, 1'b0}   // set
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // write completes with strobe rise; ends three edges later plus margin
  task automatic host_write(input logic sel, input logic cmd, input logic [7:0] d,
                            input bit ack_collide);
    @(negedge clk);
    hst_sel = sel; hst_cmd = cmd; hst_data = d; hst_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    hst_wr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (ack_collide) rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    repeat (2) @(negedge clk);
    hst_sel = 1'b0; hst_cmd = 1'b0; hst_data = 8'h00;
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hst_sel = 1'b0; hst_cmd = 1'b0; hst_wr_n = 1'b1;
    hst_data = 8'h00; gate_en = 1'b1; rd_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 gate", gate_out, 1'b0);
    check("R1 ibf", ibf, 1'b0);
    check("R1 cmd_flag", cmd_flag, 1'b0);

    // table walk: R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      host_write(VEC[i][11], VEC[i][10], VEC[i][9:2], 1'b0);
      check($sformatf("row %0d gate (R2 R4 R5 R7 R8 R9)", i), gate_out, VEC[i][1]);
      check($sformatf("row %0d cmd_flag (R3)", i), cmd_flag, VEC[i][0]);
    end

    // R11 ack clears, then unselected write leaves it clear (R2)
    check("R11 ibf set", ibf, 1'b1);
    pulse_ack();
    @(negedge clk);
    check("R11 ibf cleared", ibf, 1'b0);
    host_write(1'b0, 1'b0, 8'h00, 1'b0);
    check("R2 ibf untouched", ibf, 1'b0);
    // R11 collision: set wins
    host_write(1'b1, 1'b0, 8'h00, 1'b1);
    check("R11 set wins over ack", ibf, 1'b1);
    pulse_ack();

    // R6 latency: gate currently 1, arm then clear
    host_write(1'b1, 1'b1, 8'hD1, 1'b0);
    @(negedge clk);
    hst_sel = 1'b1; hst_cmd = 1'b0; hst_data = 8'h00; hst_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 unchanged while strobe low", gate_out, 1'b1);
    hst_wr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 unchanged after two edges", gate_out, 1'b1);
    @(negedge clk);
    check("R6 changed on third edge", gate_out, 1'b0);
    repeat (3) @(negedge clk);
    hst_sel = 1'b0;

    // R10 enable forces clear
    host_write(1'b1, 1'b1, 8'hD1, 1'b0);
    host_write(1'b1, 1'b0, 8'h02, 1'b0);
    check("R10 gate set before disable", gate_out, 1'b1);
    @(negedge clk); gate_en = 1'b0;
    @(negedge clk);
    check("R10 cleared by enable", gate_out, 1'b0);
    host_write(1'b1, 1'b1, 8'hD1, 1'b0);
    host_write(1'b1, 1'b0, 8'h02, 1'b0);
    check("R10 write ignored while disabled", gate_out, 1'b0);
    gate_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 stays low after re-enable", gate_out, 1'b0);
    host_write(1'b1, 1'b1, 8'hD1, 1'b0);
    host_write(1'b1, 1'b0, 8'h02, 1'b0);
    check("R10 armed data after re-enable", gate_out, 1'b1);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 gate after reset", gate_out, 1'b0);
    check("R1 ibf after reset", ibf, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    host_write(1'b1, 1'b0, 8'h02, 1'b0);
    check("R1 not armed after reset", gate_out, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule